// File: doc/BRIEF.md
# Direct-Mapped Write-Back Byte Cache Controller

This block sits between a processor byte port and a word-wide memory port. It caches 256 lines of 16 bytes each for a 24-bit byte address space. Every line has one fixed slot, chosen by the middle address bits. A read or write that finds its line resident completes in the same cycle it is presented, and the memory port stays idle.

On a miss the controller stalls the processor and runs a fixed procedure. An invalid slot is filled straight away. A valid slot holding another tag is first copied back to memory if it has been modified; otherwise it is overwritten. The fill arrives as two 8-byte beats. After the fill the slot is valid and clean, and the stalled request completes in the next cycle. Write misses allocate: the block is fetched first and the byte is merged afterwards.

Top module: `dmwb_cache_ctrl`

## Requirements
- R1: A byte address is split as tag = bits 23..12, line index = bits 11..4 and byte offset = bits 3..0 (0xAB7129 → tag 0xAB7, index 0x12, offset 0x9). Only the index selects the slot, and a hit needs the stored tag to match.
- R2: After reset every slot is invalid and clean, `cpu_ack`, `cpu_busy` and `mem_req` are 0, and the first access to any address misses.
- R3: A miss on an invalid slot issues no write beats. It goes directly to two read beats of the requested block.
- R4: A hit (slot valid, tag equal) raises `cpu_ack` in the cycle the request is presented, with no memory traffic. For a read, `cpu_rdata` carries the addressed byte in that cycle. A write hit updates the byte at the clock edge that ends that cycle.
- R5: A miss on a valid, clean slot holding another tag issues no write beats. The fetched block replaces the old contents.
- R6: A miss on a valid, modified slot first writes the old line back to the block address formed from its stored tag and the index. The fill follows, and later reads of the old address return the modified data.
- R7: Each line moves as two beats. Beat 0 uses block address + 0 and carries bytes 0..7, beat 1 uses block address + 8 and carries bytes 8..15. Line byte k lies at bits 8k+7..8k of its beat's 64-bit word. Write-back beats come before fill beats.
- R8: `cpu_busy` is 1 from the cycle a miss is seen until the last fill beat is accepted. `cpu_ack` rises in the cycle after that last acceptance, and `cpu_ack` and `cpu_busy` are never 1 together. With a memory that answers each request one cycle later, a clean miss acknowledges 5 cycles after the request and a dirty miss 9 cycles after.
- R9: A write miss fetches the block before merging the byte (write-allocate). The line is then modified, so the new byte reads back and is written back on eviction.
- R10: Every write hit marks the line modified, whatever its earlier state, including repeated writes to an already modified line.
- R11: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged from the cycle a beat is requested until the cycle `mem_ack` accepts it.
- R12: A fill leaves the line valid and clean. Evicting a line that was only read causes no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request present |
| cpu_we | input | 1 | 1 = byte write, 0 = byte read |
| cpu_addr | input | 24 | Byte address |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Read byte, valid with `cpu_ack` on a read |
| cpu_ack | output | 1 | Request completes this cycle |
| cpu_busy | output | 1 | Stall: miss procedure in progress |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write-back beat, 0 = fill beat |
| mem_addr | output | 24 | Beat byte address, 8-byte aligned |
| mem_wdata | output | 64 | Write-back beat data |
| mem_rdata | input | 64 | Fill beat data, sampled with `mem_ack` |
| mem_ack | input | 1 | Memory accepts the current beat |

## Verification
The assertions assume that the processor holds `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` steady from the moment a request is raised until `cpu_ack`. They also assume that the memory answers each beat with a `mem_ack` of one cycle only while `mem_req` is high. The address-relation and completion checks (fill address equal to the request's block, write-back tag differing from it, acknowledge after the final fill beat) depend on that. The bench raises each request at a falling edge and drops it only after the acknowledging edge. Its memory model raises `mem_ack` for exactly one cycle, one cycle after each pending request, so both assumptions hold throughout.

// File: rtl/cache_pkg.sv
package cache_pkg;

  // miss-procedure phases
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WBACK = 2'd1,
    PH_FILL  = 2'd2
  } miss_phase_e;

endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int LINES = 256,
  parameter int IDX_W = 8,
  parameter int TAG_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             mark_dirty_i,
  input  logic             fill_done_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  output logic             valid_o,
  output logic             dirty_o,
  output logic [TAG_W-1:0] tag_o
);

  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_done_i) begin
      valid_q[idx_i] <= 1'b1;
      dirty_q[idx_i] <= 1'b0;
    end else if (mark_dirty_i) begin
      dirty_q[idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_done_i) tag_q[idx_i] <= fill_tag_i;
  end

  assign valid_o = valid_q[idx_i];
  assign dirty_o = dirty_q[idx_i];
  assign tag_o   = tag_q[idx_i];

  // a write hit always leaves its line modified
  assert_write_marks_dirty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mark_dirty_i |=> dirty_q[$past(idx_i)]);

  // a completed fill leaves its line valid and clean
  assert_fill_leaves_clean_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done_i |=> (valid_q[$past(idx_i)] && !dirty_q[$past(idx_i)]));

endmodule

// File: rtl/cache_line_store.sv
module cache_line_store #(
  parameter int LINES      = 256,
  parameter int IDX_W      = 8,
  parameter int OFF_W      = 4,
  parameter int BEAT_BYTES = 8,
  parameter int BEAT_W     = 1
) (
  input  logic                    clk,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic [OFF_W-1:0]        byte_off_i,
  input  logic                    byte_we_i,
  input  logic [7:0]              byte_wdata_i,
  output logic [7:0]              byte_rdata_o,
  input  logic [BEAT_W-1:0]       beat_sel_i,
  input  logic                    beat_we_i,
  input  logic [BEAT_BYTES*8-1:0] beat_wdata_i,
  output logic [BEAT_BYTES*8-1:0] beat_rdata_o
);

  localparam int LINE_BYTES = 1 << OFF_W;
  localparam int LINE_BITS  = LINE_BYTES * 8;
  localparam int BEAT_BITS  = BEAT_BYTES * 8;
  localparam int BEATS      = LINE_BYTES / BEAT_BYTES;

  logic [LINE_BITS-1:0] line_q [LINES];
  logic [LINE_BYTES-1:0] lane_we;
  logic [LINE_BITS-1:0]  lane_data;

  // per-byte write enable and data, one lane per byte of the line
  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_lane
    localparam int BEAT_OF = b / BEAT_BYTES;
    localparam int POS_IN  = b % BEAT_BYTES;
    assign lane_we[b] = (byte_we_i && (byte_off_i == OFF_W'(b))) ||
                        (beat_we_i && (beat_sel_i == BEAT_W'(BEAT_OF)));
    assign lane_data[b*8 +: 8] = beat_we_i ? beat_wdata_i[POS_IN*8 +: 8] : byte_wdata_i;
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < LINE_BYTES; b++) begin
      if (lane_we[b]) line_q[idx_i][b*8 +: 8] <= lane_data[b*8 +: 8];
    end
  end

  assign byte_rdata_o = line_q[idx_i][byte_off_i*8 +: 8];
  assign beat_rdata_o = line_q[idx_i][beat_sel_i*BEAT_BITS +: BEAT_BITS];

  // byte merges and beat fills never collide
  always_comb begin
    assert_no_lane_collision_R9: assert (!(byte_we_i && beat_we_i) || BEATS == 0);
  end

endmodule

// File: rtl/cache_miss_seq.sv
module cache_miss_seq
  import cache_pkg::*;
#(
  parameter int BEATS  = 2,
  parameter int BEAT_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_i,
  input  logic              victim_dirty_i,
  input  logic              mem_ack_i,
  output miss_phase_e       phase_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic              fill_we_o,
  output logic              fill_done_o
);

  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  miss_phase_e       phase_q;
  logic [BEAT_W-1:0] beat_q;
  logic              last_beat;

  assign last_beat = (beat_q == LAST_BEAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      beat_q  <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          beat_q <= '0;
          if (miss_i) phase_q <= victim_dirty_i ? PH_WBACK : PH_FILL;
        end
        PH_WBACK: begin
          if (mem_ack_i) begin
            beat_q <= last_beat ? '0 : beat_q + 1'b1;
            if (last_beat) phase_q <= PH_FILL;
          end
        end
        PH_FILL: begin
          if (mem_ack_i) begin
            beat_q <= last_beat ? '0 : beat_q + 1'b1;
            if (last_beat) phase_q <= PH_IDLE;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o     = phase_q;
  assign beat_o      = beat_q;
  assign fill_we_o   = (phase_q == PH_FILL) && mem_ack_i;
  assign fill_done_o = fill_we_o && last_beat;

  // the write-back phase always hands over to a fill, never back to idle
  assert_wback_then_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WBACK && mem_ack_i && last_beat) |=> (phase_q == PH_FILL));

  // the phase only advances on an accepted beat
  assert_phase_waits_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE && !mem_ack_i) |=> ($stable(phase_q) && $stable(beat_q)));

endmodule

// File: rtl/dmwb_cache_ctrl.sv
module dmwb_cache_ctrl
  import cache_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int IDX_W      = 8,
  parameter int OFF_W      = 4,
  parameter int BEAT_BYTES = 8,
  localparam int MEM_W     = BEAT_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  output logic              cpu_ack,
  output logic              cpu_busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [MEM_W-1:0]  mem_wdata,
  input  logic [MEM_W-1:0]  mem_rdata,
  input  logic              mem_ack
);

  localparam int TAG_W      = ADDR_W - IDX_W - OFF_W;
  localparam int LINES      = 1 << IDX_W;
  localparam int LINE_BYTES = 1 << OFF_W;
  localparam int BOFF_W     = $clog2(BEAT_BYTES);
  localparam int BEATS      = LINE_BYTES / BEAT_BYTES;
  localparam int BEAT_W     = (OFF_W - BOFF_W) > 0 ? (OFF_W - BOFF_W) : 1;

  // ---------------- address arithmetic ----------------
  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [OFF_W-1:0] off_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction

  function automatic logic [ADDR_W-1:0] beat_addr(input logic [TAG_W-1:0] t,
                                                   input logic [IDX_W-1:0] i,
                                                   input logic [BEAT_W-1:0] b);
    logic [ADDR_W-1:0] r;
    r = '0;
    r[ADDR_W-1 -: TAG_W] = t;
    r[OFF_W +: IDX_W]    = i;
    r[BOFF_W +: BEAT_W]  = b;
    return r;
  endfunction

  // ---------------- named internal events ----------------
  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic [OFF_W-1:0]  req_off;
  logic              line_valid, line_dirty;
  logic [TAG_W-1:0]  line_tag;
  logic              hit_w, miss_w, idle_w, wr_hit_w;
  logic              victim_dirty_w;
  miss_phase_e       phase;
  logic [BEAT_W-1:0] beat;
  logic              fill_we_w, fill_done_w;
  logic [MEM_W-1:0]  line_beat;

  assign req_tag = tag_of(cpu_addr);
  assign req_idx = idx_of(cpu_addr);
  assign req_off = off_of(cpu_addr);

  assign idle_w         = (phase == PH_IDLE);
  assign hit_w          = line_valid && (line_tag == req_tag);
  assign miss_w         = idle_w && cpu_req && !hit_w;
  assign victim_dirty_w = line_valid && line_dirty;
  assign wr_hit_w       = cpu_ack && cpu_we;

  cache_tag_store #(
    .LINES (LINES),
    .IDX_W (IDX_W),
    .TAG_W (TAG_W)
  ) u_tags (
    .clk          (clk),
    .rst_n        (rst_n),
    .idx_i        (req_idx),
    .mark_dirty_i (wr_hit_w),
    .fill_done_i  (fill_done_w),
    .fill_tag_i   (req_tag),
    .valid_o      (line_valid),
    .dirty_o      (line_dirty),
    .tag_o        (line_tag)
  );

  cache_line_store #(
    .LINES      (LINES),
    .IDX_W      (IDX_W),
    .OFF_W      (OFF_W),
    .BEAT_BYTES (BEAT_BYTES),
    .BEAT_W     (BEAT_W)
  ) u_lines (
    .clk          (clk),
    .idx_i        (req_idx),
    .byte_off_i   (req_off),
    .byte_we_i    (wr_hit_w),
    .byte_wdata_i (cpu_wdata),
    .byte_rdata_o (cpu_rdata),
    .beat_sel_i   (beat),
    .beat_we_i    (fill_we_w),
    .beat_wdata_i (mem_rdata),
    .beat_rdata_o (line_beat)
  );

  cache_miss_seq #(
    .BEATS  (BEATS),
    .BEAT_W (BEAT_W)
  ) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .miss_i         (miss_w),
    .victim_dirty_i (victim_dirty_w),
    .mem_ack_i      (mem_ack),
    .phase_o        (phase),
    .beat_o         (beat),
    .fill_we_o      (fill_we_w),
    .fill_done_o    (fill_done_w)
  );

  // ---------------- ports ----------------
  assign cpu_ack   = idle_w && cpu_req && hit_w;
  assign cpu_busy  = !idle_w || miss_w;
  assign mem_req   = !idle_w;
  assign mem_we    = (phase == PH_WBACK);
  assign mem_addr  = beat_addr(mem_we ? line_tag : req_tag, req_idx, beat);
  assign mem_wdata = line_beat;

  // ---------------- assertions ----------------
  assert_ack_busy_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_ack && cpu_busy));

  assert_ack_after_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done_w |=> cpu_ack);

  assert_fill_targets_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_addr[ADDR_W-1:OFF_W] == cpu_addr[ADDR_W-1:OFF_W]));

  assert_wback_targets_victim_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> ((mem_addr[ADDR_W-1 -: TAG_W] != req_tag) &&
                             (mem_addr[OFF_W +: IDX_W] == req_idx)));

  assert_beat_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) &&
                               $stable(mem_wdata)));

  assert_no_traffic_on_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |-> !mem_req);

endmodule

// File: tb/dmwb_cache_ctrl_bench.sv
`timescale 1ns/1ps
module dmwb_cache_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [23:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        cpu_ack, cpu_busy;
  logic        mem_req, mem_we;
  logic [23:0] mem_addr;
  logic [63:0] mem_wdata;
  logic [63:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  always #4 clk = ~clk;

  dmwb_cache_ctrl u_dmwb_cache_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack), .cpu_busy(cpu_busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  int tests = 0, fails = 0;
  int wr_beats = 0, rd_beats = 0, hold_viol = 0, busy_err = 0;
  logic [23:0] wr_log [64];
  logic [23:0] rd_log [64];
  logic [7:0]  bmem [int];
  logic [7:0]  rmem [int];

  function automatic logic [7:0] init_byte(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return bmem.exists(int'(a)) ? bmem[int'(a)] : init_byte(a);
  endfunction

  function automatic logic [7:0] exp_byte(input logic [23:0] a);
    return rmem.exists(int'(a)) ? rmem[int'(a)] : init_byte(a);
  endfunction

  // behavioural memory: answers every pending beat one cycle later
  logic        pend_q = 1'b0;
  logic [23:0] pend_addr = '0;
  always @(posedge clk) begin
    if (pend_q && (!mem_req || mem_addr != pend_addr)) hold_viol++;
    pend_q    <= mem_req && !mem_ack;
    pend_addr <= mem_addr;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        wr_log[wr_beats % 64] = mem_addr;
        wr_beats++;
        for (int k = 0; k < 8; k++) bmem[int'(mem_addr) + k] = mem_wdata[k*8 +: 8];
      end else begin
        logic [63:0] w;
        rd_log[rd_beats % 64] = mem_addr;
        rd_beats++;
        for (int k = 0; k < 8; k++) w[k*8 +: 8] = mem_byte(mem_addr + 24'(k));
        mem_rdata <= w;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // one processor access; returns byte, stall cycles and beat counts
  task automatic access(input bit we, input logic [23:0] a, input logic [7:0] d,
                        output logic [7:0] rd, output int cyc, output int dw, output int dr);
    int w0, r0;
    w0 = wr_beats; r0 = rd_beats;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    cyc = 0;
    forever begin
      #1;
      if (cpu_ack) break;
      if (!cpu_busy) busy_err++;
      @(negedge clk);
      cyc++;
    end
    rd = cpu_rdata;
    if (we) rmem[int'(a)] = d;
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
    dw = wr_beats - w0; dr = rd_beats - r0;
  endtask

  logic [7:0] rd;
  int cyc, dw, dr, wbase, rbase;

  task automatic t_reset();
    check(!cpu_ack && !cpu_busy && !mem_req, "R2", "idle outputs after reset",
          {cpu_ack, cpu_busy, mem_req}, 0);
  endtask

  task automatic t_cold_miss();
    rbase = rd_beats;
    access(0, 24'hAB7129, 8'h00, rd, cyc, dw, dr);
    check(rd == exp_byte(24'hAB7129), "R1", "cold read byte", rd, exp_byte(24'hAB7129));
    check(dw == 0 && dr == 2, "R3", "invalid slot beats wr*16+rd", dw*16 + dr, 2);
    check(cyc == 5, "R8", "clean miss latency", cyc, 5);
    check(rd_log[rbase % 64] == 24'hAB7120 && rd_log[(rbase+1) % 64] == 24'hAB7128,
          "R7", "fill beat addresses", rd_log[(rbase+1) % 64], 24'hAB7128);
    check(busy_err == 0, "R8", "busy during stall", busy_err, 0);
  endtask

  task automatic t_hits();
    access(0, 24'hAB712F, 8'h00, rd, cyc, dw, dr);
    check(cyc == 0 && dw + dr == 0, "R4", "read hit no traffic", cyc*16 + dw + dr, 0);
    check(rd == exp_byte(24'hAB712F), "R7", "upper beat byte lane", rd, exp_byte(24'hAB712F));
    access(1, 24'hAB7125, 8'h5A, rd, cyc, dw, dr);
    check(cyc == 0 && dw + dr == 0, "R4", "write hit no traffic", cyc*16 + dw + dr, 0);
    access(1, 24'hAB7125, 8'h77, rd, cyc, dw, dr);
    check(cyc == 0, "R10", "second write to dirty line hits", cyc, 0);
    access(0, 24'hAB7125, 8'h00, rd, cyc, dw, dr);
    check(rd == 8'h77, "R4", "write hit readback", rd, 8'h77);
  endtask

  task automatic t_index_split();
    access(0, 24'hAB7139, 8'h00, rd, cyc, dw, dr);
    check(cyc == 5 && dw == 0, "R1", "same tag other index misses cleanly", cyc, 5);
    access(0, 24'hAB7124, 8'h00, rd, cyc, dw, dr);
    check(cyc == 0, "R1", "original index still resident", cyc, 0);
  endtask

  task automatic t_dirty_evict();
    wbase = wr_beats;
    access(0, 24'hCD4124, 8'h00, rd, cyc, dw, dr);
    check(dw == 2 && dr == 2, "R6", "dirty evict beats wr*16+rd", dw*16 + dr, 34);
    check(wr_log[wbase % 64] == 24'hAB7120 && wr_log[(wbase+1) % 64] == 24'hAB7128,
          "R6", "write-back addresses", wr_log[wbase % 64], 24'hAB7120);
    check(mem_byte(24'hAB7125) == 8'h77, "R7", "written-back byte lane",
          mem_byte(24'hAB7125), 8'h77);
    check(mem_byte(24'hAB712F) == init_byte(24'hAB712F), "R6", "untouched byte written back",
          mem_byte(24'hAB712F), init_byte(24'hAB712F));
    check(cyc == 9, "R8", "dirty miss latency", cyc, 9);
    check(rd == exp_byte(24'hCD4124), "R5", "new block byte", rd, exp_byte(24'hCD4124));
  endtask

  task automatic t_clean_evict();
    access(0, 24'h111120, 8'h00, rd, cyc, dw, dr);
    check(dw == 0 && dr == 2, "R12", "read-only line evicts clean", dw*16 + dr, 2);
    check(rd == exp_byte(24'h111120), "R5", "replaced contents", rd, exp_byte(24'h111120));
    access(0, 24'hAB7125, 8'h00, rd, cyc, dw, dr);
    check(rd == 8'h77 && dw == 0, "R6", "modified data survives eviction", rd, 8'h77);
  endtask

  task automatic t_write_miss();
    wbase = wr_beats;
    access(1, 24'h3456A3, 8'hC3, rd, cyc, dw, dr);
    check(cyc == 5 && dw == 0 && dr == 2, "R9", "write miss allocates", cyc*16 + dw*4 + dr, 82);
    access(0, 24'h3456A3, 8'h00, rd, cyc, dw, dr);
    check(rd == 8'hC3 && cyc == 0, "R9", "merged byte", rd, 8'hC3);
    access(0, 24'h3456A4, 8'h00, rd, cyc, dw, dr);
    check(rd == exp_byte(24'h3456A4), "R9", "fetched neighbour byte", rd, exp_byte(24'h3456A4));
    wbase = wr_beats;
    access(0, 24'h9996A0, 8'h00, rd, cyc, dw, dr);
    check(dw == 2 && wr_log[wbase % 64] == 24'h3456A0, "R10", "allocated write is dirty",
          dw, 2);
    check(mem_byte(24'h3456A3) == 8'hC3, "R9", "merged byte written back",
          mem_byte(24'h3456A3), 8'hC3);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_cold_miss();
    t_hits();
    t_index_split();
    t_dirty_evict();
    t_clean_evict();
    t_write_miss();
    check(hold_viol == 0, "R11", "beat held until ack", hold_viol, 0);
    check(busy_err == 0, "R8", "busy over all stalls", busy_err, 0);
    repeat (2) @(negedge clk);
    report();
  end

endmodule